// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the two ALU operands for the execute stage of a five-stage in-order pipeline. The values read from the register file in decode can be stale: a result that is still in flight in the memory stage or the writeback stage may not have reached the register file yet. For each source register of the instruction in execute, the block compares the register number against the destination of the two older instructions still in the pipeline. It then takes the newest matching result in place of the register-file value.

The selector is purely combinational and has no state. Each operand has its own bypass decision, and both decisions are exposed as 2-bit select codes. On the second operand, a later 2-to-1 stage can replace the bypassed value with the sign-extended immediate. The bypassed second-operand value, taken before that immediate stage, is also driven out as the data that a store writes to memory. Every port is a plain control or data pin with no handshake, because the result follows the inputs within the same cycle.

Top module: `op_forward_unit`

## Requirements
- R1: When `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `src_a`, then `sel_a` is 2'b10 and `alu_op_a` equals `mem_result`.
- R2: When `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `src_b`, then `sel_b` is 2'b10 and the bypassed second operand (`store_data`) equals `mem_result`.
- R3: When the memory-stage condition of R1/R2 does not hold for a source, but `wb_wen` is 1, `wb_dst` is nonzero and `wb_dst` equals that source, then its select is 2'b01 and its operand equals `wb_value`.
- R4: When both stages match the same source under R1–R3, the memory-stage result wins: the select is 2'b10 and the operand is `mem_result`.
- R5: Register 0 is never bypassed. A destination of 0 never produces select 2'b10 or 2'b01, even with its write enable at 1 and a matching source of 0.
- R6: A stage whose write enable is 0 never supplies an operand. A memory-stage match with `mem_wen` at 0 does not stop a valid writeback-stage match from being bypassed.
- R7: With no qualifying match, the select is 2'b00 and the operand is the register-file value (`rdata_a` or `rdata_b`). Code 2'b11 is never produced.
- R8: When `use_imm` is 1, `alu_op_b` equals `imm_ext`, while `sel_b`, `store_data` and the whole first-operand path are unchanged. When `use_imm` is 0, `alu_op_b` equals `store_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| rdata_a | input | 32 | Register-file value read in decode for `src_a` |
| rdata_b | input | 32 | Register-file value read in decode for `src_b` |
| mem_dst | input | 5 | Destination register of the instruction in the memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| mem_result | input | 32 | ALU result held in the memory stage |
| wb_dst | input | 5 | Destination register of the instruction in writeback |
| wb_wen | input | 1 | Writeback-stage instruction writes the register file |
| wb_value | input | 32 | Value being written back |
| imm_ext | input | 32 | Sign-extended immediate of the instruction in execute |
| use_imm | input | 1 | Second ALU operand comes from the immediate |
| alu_op_a | output | 32 | Final first ALU operand |
| alu_op_b | output | 32 | Final second ALU operand |
| store_data | output | 32 | Bypassed second operand before the immediate stage |
| sel_a | output | 2 | Bypass code for operand A: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Bypass code for operand B, same encoding |

## Verification
Two cases can occur in the same cycle. In the first, both older instructions write the same register that a source names; the bench sets both destinations equal to the source and expects code 10 with the memory-stage value. It also sends one operand to each stage in a single vector, so the two operand paths are shown to be independent. In the second, a bypass and the immediate select both act on operand B; the bench expects the immediate on `alu_op_b` while `store_data` and `sel_b` still report the bypassed value. Register-0 destinations and disabled write enables are driven with matching sources to show that they are filtered out.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_sel_logic.sv
module fwd_sel_logic
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // a producer qualifies only if it writes, targets a real register, and matches
  assign mem_hit = mem_wen && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign wb_hit  = wb_wen  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  // newer producer takes priority
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  always_comb begin
    if (!$isunknown({src, mem_dst, mem_wen, wb_dst, wb_wen})) begin
      p_no_code3_r7: assert (sel != 2'b11);
      p_zero_never_fwd_r5: assert (!(src == ZERO_REG && sel != FWD_RF));
      p_wb_needs_write_r6: assert (!(sel == FWD_WB && !wb_wen));
      p_mem_needs_write_r6: assert (!(sel == FWD_MEM && !mem_wen));
      p_wb_loses_to_mem_r4: assert (!(sel == FWD_WB && mem_wen && mem_dst == src));
    end
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] out_val
);
  always_comb begin
    case (sel)
      FWD_MEM: out_val = mem_val;
      FWD_WB:  out_val = wb_val;
      default: out_val = rf_val;   // 00 and the unused 11
    endcase
  end
endmodule

// File: rtl/op_forward_unit.sv
module op_forward_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [DATA_W-1:0] rdata_a,
  input  logic [DATA_W-1:0] rdata_b,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wen,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wen,
  input  logic [DATA_W-1:0] wb_value,
  input  logic [DATA_W-1:0] imm_ext,
  input  logic              use_imm,
  output logic [DATA_W-1:0] alu_op_a,
  output logic [DATA_W-1:0] alu_op_b,
  output logic [DATA_W-1:0] store_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0]  op_src [NUM_OPS];
  logic [DATA_W-1:0] op_rf  [NUM_OPS];
  logic [1:0]        op_sel [NUM_OPS];
  logic [DATA_W-1:0] op_fwd [NUM_OPS];

  assign op_src[0] = src_a;
  assign op_src[1] = src_b;
  assign op_rf[0]  = rdata_a;
  assign op_rf[1]  = rdata_b;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_operand
    fwd_sel_logic #(.REG_W(REG_W)) u_sel (
      .src     (op_src[i]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (op_sel[i])
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (op_sel[i]),
      .rf_val  (op_rf[i]),
      .mem_val (mem_result),
      .wb_val  (wb_value),
      .out_val (op_fwd[i])
    );
  end

  assign sel_a      = op_sel[0];
  assign sel_b      = op_sel[1];
  assign alu_op_a   = op_fwd[0];
  assign store_data = op_fwd[1];

  // immediate choice sits after the bypass mux on the second operand
  assign alu_op_b = use_imm ? imm_ext : op_fwd[1];

  always_comb begin
    if (!$isunknown({src_a, src_b, mem_dst, mem_wen, wb_dst, wb_wen, use_imm,
                     rdata_a, rdata_b, mem_result, wb_value, imm_ext})) begin
      p_mem_data_a_r1: assert (!(sel_a == FWD_MEM && alu_op_a != mem_result));
      p_mem_data_b_r2: assert (!(sel_b == FWD_MEM && store_data != mem_result));
      p_wb_data_a_r3:  assert (!(sel_a == FWD_WB && alu_op_a != wb_value));
      p_rf_data_a_r7:  assert (!(sel_a == FWD_RF && alu_op_a != rdata_a));
      p_rf_data_b_r7:  assert (!(sel_b == FWD_RF && store_data != rdata_b));
      p_imm_select_r8: assert (!(use_imm && alu_op_b != imm_ext));
      p_reg_select_r8: assert (!(!use_imm && alu_op_b != store_data));
    end
  end
endmodule

// File: tb/op_forward_unit_test.sv
module op_forward_unit_test;
  localparam time HALF = 4ns;   // 125 MHz

  typedef struct {
    string       tag;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] st;
    logic [1:0]  sa;
    logic [1:0]  sb;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #HALF clk = ~clk;

  logic [4:0]  src_a = '0, src_b = '0, mem_dst = '0, wb_dst = '0;
  logic        mem_wen = 1'b0, wb_wen = 1'b0, use_imm = 1'b0;
  logic [31:0] rdata_a = '0, rdata_b = '0, mem_result = '0, wb_value = '0, imm_ext = '0;
  logic [31:0] alu_op_a, alu_op_b, store_data;
  logic [1:0]  sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  localparam logic [31:0] RA = 32'hA0A0_0001;
  localparam logic [31:0] RB = 32'hB0B0_0002;
  localparam logic [31:0] MR = 32'hC0C0_0003;
  localparam logic [31:0] WV = 32'hD0D0_0004;
  localparam logic [31:0] IM = 32'h0000_FFF0;

  op_forward_unit uut (
    .src_a(src_a), .src_b(src_b), .rdata_a(rdata_a), .rdata_b(rdata_b),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_result(mem_result),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_value(wb_value),
    .imm_ext(imm_ext), .use_imm(use_imm),
    .alu_op_a(alu_op_a), .alu_op_b(alu_op_b), .store_data(store_data),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  task automatic drive(input string tag, input logic [4:0] sa, input logic [4:0] sbr,
                       input logic [4:0] md, input logic mw, input logic [4:0] wd,
                       input logic ww, input logic ui, input logic [31:0] ea,
                       input logic [31:0] eb, input logic [31:0] es,
                       input logic [1:0] esa, input logic [1:0] esb);
    exp_t e;
    @(posedge clk);
    src_a = sa; src_b = sbr; mem_dst = md; mem_wen = mw;
    wb_dst = wd; wb_wen = ww; use_imm = ui;
    e.tag = tag; e.op_a = ea; e.op_b = eb; e.st = es; e.sa = esa; e.sb = esb;
    sb_q.push_back(e);
  endtask

  // monitor: compares at the falling edge, half a cycle after each drive
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (alu_op_a !== e.op_a || alu_op_b !== e.op_b || store_data !== e.st ||
          sel_a !== e.sa || sel_b !== e.sb) begin
        errors++;
        $display("FAIL %s: actual a=%h b=%h st=%h sa=%b sb=%b expected a=%h b=%h st=%h sa=%b sb=%b",
                 e.tag, alu_op_a, alu_op_b, store_data, sel_a, sel_b,
                 e.op_a, e.op_b, e.st, e.sa, e.sb);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all inputs zero, everything reads zero (R7)
    drive("R7 reset", 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, '0, '0, '0, 2'b00, 2'b00);
    @(posedge clk);
    rdata_a = RA; rdata_b = RB; mem_result = MR; wb_value = WV; imm_ext = IM;
    drive("R7 no match", 5'd3, 5'd4, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, RA, RB, RB, 2'b00, 2'b00);
    drive("R1 mem to A", 5'd5, 5'd4, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, MR, RB, RB, 2'b10, 2'b00);
    drive("R2 mem to B", 5'd3, 5'd5, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0, RA, MR, MR, 2'b00, 2'b10);
    drive("R3 wb to A",  5'd3, 5'd4, 5'd9, 1'b1, 5'd3, 1'b1, 1'b0, WV, RB, RB, 2'b01, 2'b00);
    drive("R3 wb to B",  5'd3, 5'd4, 5'd9, 1'b1, 5'd4, 1'b1, 1'b0, RA, WV, WV, 2'b00, 2'b01);
    drive("R4 both match", 5'd7, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 1'b0, MR, MR, MR, 2'b10, 2'b10);
    drive("R4 split stages", 5'd7, 5'd8, 5'd7, 1'b1, 5'd8, 1'b1, 1'b0, MR, WV, WV, 2'b10, 2'b01);
    drive("R5 zero both", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, RA, RB, RB, 2'b00, 2'b00);
    drive("R5 zero mem", 5'd0, 5'd6, 5'd0, 1'b1, 5'd6, 1'b1, 1'b0, RA, WV, WV, 2'b00, 2'b01);
    drive("R6 mem off", 5'd5, 5'd4, 5'd5, 1'b0, 5'd6, 1'b1, 1'b0, RA, RB, RB, 2'b00, 2'b00);
    drive("R6 mem off wb on", 5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 1'b0, WV, WV, WV, 2'b01, 2'b01);
    drive("R6 wb off", 5'd3, 5'd4, 5'd9, 1'b1, 5'd4, 1'b0, 1'b0, RA, RB, RB, 2'b00, 2'b00);
    drive("R8 imm over mem", 5'd3, 5'd5, 5'd5, 1'b1, 5'd6, 1'b1, 1'b1, RA, IM, MR, 2'b00, 2'b10);
    drive("R8 imm no fwd", 5'd3, 5'd4, 5'd9, 1'b1, 5'd6, 1'b1, 1'b1, RA, IM, RB, 2'b00, 2'b00);
    drive("R8 imm over wb", 5'd6, 5'd6, 5'd9, 1'b1, 5'd6, 1'b1, 1'b1, WV, IM, WV, 2'b01, 2'b01);
    drive("R8 imm released", 5'd6, 5'd6, 5'd9, 1'b1, 5'd6, 1'b1, 1'b0, WV, WV, WV, 2'b01, 2'b01);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule